// File: doc/BRIEF.md
# YCbCr 4:2:2 Multiplexed Input Deinterleaver

This block sits at a video input and turns a single multiplexed sample bus, which carries chroma and luma in alternation, into one parallel pixel per output strobe. Each output pixel carries a luma sample, the chroma sample it shares with its neighbour, and a flag that tells whether that chroma is Cb or Cr. Along each active line the bus carries Cb, Y, Cr, Y and then repeats. One Cb/Cr pair serves two consecutive luma samples.

Two capture schemes are supported. In the single-edge scheme the input clock runs at twice the pixel rate and one sample is taken on each rising edge. In the double-edge scheme the clock runs at the pixel rate and a sample is taken on each edge. A configuration bit picks whether the rising or the falling edge carries the chroma half of a pixel. The sample width is 12, 10 or 8 bits. Narrow samples come from the low bits of the bus and leave the block left-justified in 12 bits.

Pixel alignment restarts at every rising edge of the data-enable input. The configuration inputs are taken only while data enable is low, so a line never changes mode partway through.

Top module: `ycc422_deinterleave`

## Requirements
- R1: With `cfg_ddr`=0, one sample is taken per rising edge while `vid_de` is high. The first sample of each pair is chroma and the second is luma, and the two form one pixel.
- R2: Chroma alternates Cb then Cr within a line. `pix_is_cb` is 1 for even pixels (0, 2, 4, ...) and 0 for odd pixels, counted from the start of the line.
- R3: The sample taken at the first edge with `vid_de` high is always the chroma of pixel 0 (a Cb pixel), whatever happened on the previous line.
- R4: A pixel whose luma sample is not taken with `vid_de` high (data enable falls after its chroma) is dropped, and no `pix_valid` is raised for it.
- R5: With `cfg_ddr`=1 and `cfg_rise_first`=1, the sample on a rising edge is the chroma and the sample on the following falling edge is the luma of the same pixel.
- R6: With `cfg_ddr`=1 and `cfg_rise_first`=0, the sample on a falling edge is the chroma and the sample on the following rising edge is the luma of the same pixel.
- R7: `cfg_width` 2'b00 takes `vid_data[11:0]`. 2'b01 takes `vid_data[9:0]` and outputs it shifted left by 2. 2'b10 and 2'b11 take `vid_data[7:0]` and output it shifted left by 4. Padding bits are zero and unused upper input bits have no effect.
- R8: `pix_valid` is registered and high for exactly one clock per completed pixel. It rises at the first rising edge after the edge that captured the pixel's luma sample.
- R9: The configuration inputs are taken at a rising edge only while `vid_de` is low. Changes made while `vid_de` is high have no effect on the current line.
- R10: Synchronous active-high reset clears `pix_valid`, `pix_luma`, `pix_chroma` and `pix_is_cb` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock (2x pixel rate, or pixel rate for double-edge capture) |
| rst | input | 1 | Synchronous active-high reset |
| vid_de | input | 1 | Data enable of the multiplexed input |
| vid_data | input | 12 | Multiplexed chroma/luma sample bus |
| cfg_ddr | input | 1 | 1 selects double-edge capture, 0 selects single-edge 2x capture |
| cfg_rise_first | input | 1 | Double-edge only: 1 puts chroma on the rising edge, 0 on the falling edge |
| cfg_width | input | 2 | Sample width: 00 = 12, 01 = 10, 10/11 = 8 bits |
| pix_valid | output | 1 | One-cycle strobe per completed pixel |
| pix_luma | output | 12 | Left-justified luma of the pixel |
| pix_chroma | output | 12 | Left-justified chroma of the pixel |
| pix_is_cb | output | 1 | 1 when `pix_chroma` is Cb, 0 when it is Cr |

## Verification
The bench builds the block with its default 12-bit bus. It sweeps all three capture schemes against all four width codes and every line length from one to seven samples. This covers both even and odd line lengths, so the dropped trailing half-pixel and the restart of Cb/Cr parity on the next line are hit in every scheme and width. Sample values use all twelve bus bits, so leaking upper bits in the narrow modes shows up directly in the output. A further line changes the mode and width inputs while enable is high, to show that they are held off until the blanking gap.

// File: rtl/ycc_deint_pkg.sv
`timescale 1ns/1ps
package ycc_deint_pkg;

    localparam int BUS_W  = 12;
    localparam int PAD_10 = BUS_W - 10;
    localparam int PAD_8  = BUS_W - 8;

    typedef enum logic [1:0] {
        WID_12  = 2'b00,
        WID_10  = 2'b01,
        WID_8   = 2'b10,
        WID_8B  = 2'b11
    } width_e;

    typedef struct packed {
        logic   ddr;
        logic   rise_first;
        width_e width;
    } cfg_t;

    typedef struct packed {
        logic [BUS_W-1:0] val;
        logic             en;
    } smp_t;

    typedef struct packed {
        logic [BUS_W-1:0] luma;
        logic [BUS_W-1:0] chroma;
        logic             is_cb;
    } pix_t;

    localparam cfg_t CFG_RESET = '{ddr: 1'b0, rise_first: 1'b1, width: WID_12};

    function automatic logic [BUS_W-1:0] left_justify(input logic [BUS_W-1:0] raw,
                                                      input width_e w);
        logic [BUS_W-1:0] r;
        case (w)
            WID_12:  r = raw;
            WID_10:  r = {raw[BUS_W-PAD_10-1:0], {PAD_10{1'b0}}};
            default: r = {raw[BUS_W-PAD_8-1:0], {PAD_8{1'b0}}};
        endcase
        return r;
    endfunction

endpackage

// File: rtl/ycc_deint_capture.sv
`timescale 1ns/1ps
module ycc_deint_capture
    import ycc_deint_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [BUS_W-1:0] din,
    input  logic             de_in,
    output smp_t             pos_q,
    output smp_t             neg_q,
    output smp_t             hold_q
);

    // Rising-edge sample, and a copy of the preceding falling-edge sample
    // moved into the rising-edge domain.
    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q  <= '0;
            hold_q <= '0;
        end else begin
            pos_q  <= smp_t'{val: din, en: de_in};
            hold_q <= neg_q;
        end
    end

    // Falling-edge sample, used only for double-edge capture.
    always_ff @(negedge clk) begin
        if (rst) neg_q <= '0;
        else     neg_q <= smp_t'{val: din, en: de_in};
    end

endmodule

// File: rtl/ycc_deint_cfg.sv
`timescale 1ns/1ps
module ycc_deint_cfg
    import ycc_deint_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic de_in,
    input  cfg_t cfg_in,
    output cfg_t cfg_q
);

    // Configuration is only taken in blanking so a line never mixes modes.
    always_ff @(posedge clk) begin
        if (rst)        cfg_q <= CFG_RESET;
        else if (!de_in) cfg_q <= cfg_in;
    end

endmodule

// File: rtl/ycc_deint_pair.sv
`timescale 1ns/1ps
module ycc_deint_pair
    import ycc_deint_pkg::*;
(
    input  cfg_t cfg,
    input  smp_t pos_s,
    input  smp_t neg_s,
    input  smp_t hold_s,
    output smp_t first_s,
    output smp_t second_s
);

    // Picks which captured samples form the chroma/luma halves this cycle.
    // Single-edge: second_s carries the sample just taken.
    always_comb begin
        if (!cfg.ddr) begin
            first_s  = pos_s;
            second_s = pos_s;
        end else if (cfg.rise_first) begin
            first_s  = pos_s;
            second_s = neg_s;
        end else begin
            first_s  = hold_s;
            second_s = pos_s;
        end
    end

endmodule

// File: rtl/ycc_deint_assemble.sv
`timescale 1ns/1ps
module ycc_deint_assemble
    import ycc_deint_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  cfg_t cfg,
    input  smp_t first_s,
    input  smp_t second_s,
    output logic pix_valid,
    output pix_t pix_q
);

    logic             phase;     // single-edge: 1 when chroma is held
    logic             par;       // pixel parity within line
    logic             last_en;   // enable of the last consumed sample
    logic [BUS_W-1:0] chroma_q;

    logic             par_now;
    logic [BUS_W-1:0] chroma_src;
    logic             emit_2x;
    logic             emit_ddr;
    logic             emit;

    assign emit_2x  = !cfg.ddr && second_s.en && last_en && phase;
    assign emit_ddr = cfg.ddr && first_s.en && second_s.en;
    assign emit     = emit_2x || emit_ddr;

    always_comb begin
        if (cfg.ddr) begin
            par_now    = last_en ? par : 1'b0;
            chroma_src = first_s.val;
        end else begin
            par_now    = par;
            chroma_src = chroma_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pix_valid <= 1'b0;
            pix_q     <= '0;
            phase     <= 1'b0;
            par       <= 1'b0;
            last_en   <= 1'b0;
            chroma_q  <= '0;
        end else begin
            pix_valid <= emit;
            if (emit) begin
                pix_q.luma   <= left_justify(second_s.val, cfg.width);
                pix_q.chroma <= left_justify(chroma_src, cfg.width);
                pix_q.is_cb  <= ~par_now;
                par          <= ~par_now;
            end
            if (cfg.ddr) begin
                phase   <= 1'b0;
                last_en <= first_s.en & second_s.en;
            end else begin
                last_en <= second_s.en;
                if (!second_s.en) begin
                    phase <= 1'b0;
                end else if (!last_en || !phase) begin
                    chroma_q <= second_s.val;
                    phase    <= 1'b1;
                    if (!last_en) par <= 1'b0;
                end else begin
                    phase <= 1'b0;
                end
            end
        end
    end

    // R8: in single-edge capture two pixels can never be back to back
    a_r8_gap_in_2x: assert property (@(posedge clk) disable iff (rst)
        (pix_valid && !$past(cfg.ddr) && !$past(cfg.ddr, 2)) |-> !$past(pix_valid));

    // R4: a strobe only follows a luma half that was taken with enable high
    a_r4_luma_enabled: assert property (@(posedge clk) disable iff (rst)
        pix_valid |-> $past(second_s.en));

    // R7: padding bits are zero in the narrow modes
    a_r7_pad8_zero: assert property (@(posedge clk) disable iff (rst)
        (pix_valid && $past(cfg.width[1])) |-> (pix_q.luma[PAD_8-1:0] == '0 && pix_q.chroma[PAD_8-1:0] == '0));

    a_r7_pad10_zero: assert property (@(posedge clk) disable iff (rst)
        (pix_valid && $past(cfg.width) == WID_10) |-> (pix_q.luma[PAD_10-1:0] == '0 && pix_q.chroma[PAD_10-1:0] == '0));

endmodule

// File: rtl/ycc422_deinterleave.sv
`timescale 1ns/1ps
module ycc422_deinterleave
    import ycc_deint_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             vid_de,
    input  logic [BUS_W-1:0] vid_data,
    input  logic             cfg_ddr,
    input  logic             cfg_rise_first,
    input  logic [1:0]       cfg_width,
    output logic             pix_valid,
    output logic [BUS_W-1:0] pix_luma,
    output logic [BUS_W-1:0] pix_chroma,
    output logic             pix_is_cb
);

    cfg_t cfg_in;
    cfg_t cfg_q;
    smp_t pos_s;
    smp_t neg_s;
    smp_t hold_s;
    smp_t first_s;
    smp_t second_s;
    pix_t pix_q;

    assign cfg_in = '{ddr: cfg_ddr, rise_first: cfg_rise_first, width: width_e'(cfg_width)};

    ycc_deint_cfg u_cfg (
        .clk    (clk),
        .rst    (rst),
        .de_in  (vid_de),
        .cfg_in (cfg_in),
        .cfg_q  (cfg_q)
    );

    ycc_deint_capture u_capture (
        .clk    (clk),
        .rst    (rst),
        .din    (vid_data),
        .de_in  (vid_de),
        .pos_q  (pos_s),
        .neg_q  (neg_s),
        .hold_q (hold_s)
    );

    ycc_deint_pair u_pair (
        .cfg      (cfg_q),
        .pos_s    (pos_s),
        .neg_s    (neg_s),
        .hold_s   (hold_s),
        .first_s  (first_s),
        .second_s (second_s)
    );

    ycc_deint_assemble u_assemble (
        .clk       (clk),
        .rst       (rst),
        .cfg       (cfg_q),
        .first_s   (first_s),
        .second_s  (second_s),
        .pix_valid (pix_valid),
        .pix_q     (pix_q)
    );

    assign pix_luma   = pix_q.luma;
    assign pix_chroma = pix_q.chroma;
    assign pix_is_cb  = pix_q.is_cb;

    // R9: configuration held while enable was high at the previous edge
    a_r9_cfg_held: assert property (@(posedge clk) disable iff (rst)
        $past(vid_de) |-> $stable(cfg_q));

endmodule

// File: tb/ycc422_deinterleave_tb.sv
`timescale 1ns/1ps
module ycc422_deinterleave_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        vid_de = 1'b0;
    logic [11:0] vid_data = 12'h000;
    logic        cfg_ddr = 1'b0;
    logic        cfg_rise_first = 1'b1;
    logic [1:0]  cfg_width = 2'b00;
    logic        pix_valid;
    logic [11:0] pix_luma;
    logic [11:0] pix_chroma;
    logic        pix_is_cb;

    int cyc = 0;
    int checks = 0;
    int fails = 0;

    typedef struct {
        logic [11:0] y;
        logic [11:0] c;
        logic        cb;
        int          edge_n;
        int          mode;
        int          first;
        int          r9;
    } exp_t;

    exp_t q[$];

    always #10 clk = ~clk;   // 50 MHz

    always @(posedge clk) cyc <= cyc + 1;

    ycc422_deinterleave dut_i (
        .clk            (clk),
        .rst            (rst),
        .vid_de         (vid_de),
        .vid_data       (vid_data),
        .cfg_ddr        (cfg_ddr),
        .cfg_rise_first (cfg_rise_first),
        .cfg_width      (cfg_width),
        .pix_valid      (pix_valid),
        .pix_luma       (pix_luma),
        .pix_chroma     (pix_chroma),
        .pix_is_cb      (pix_is_cb)
    );

    function automatic logic [11:0] just(input logic [11:0] d, input int w);
        if (w == 0)      return d;
        else if (w == 1) return {d[9:0], 2'b00};
        else             return {d[7:0], 4'b0000};
    endfunction

    function automatic logic [11:0] smp(input int seed, input int i);
        return 12'((seed * 293 + i * 1371 + 45) & 12'hFFF);
    endfunction

    task automatic push(input logic [11:0] c, input logic [11:0] y, input int k,
                        input int edge_n, input int mode, input int w, input int r9);
        exp_t e;
        e.c = just(c, w);
        e.y = just(y, w);
        e.cb = (k % 2 == 0);
        e.edge_n = edge_n;
        e.mode = mode;
        e.first = (k == 0);
        e.r9 = r9;
        q.push_back(e);
    endtask

    // Output monitor, sampling mid-cycle after each rising edge
    always @(posedge clk) begin
        exp_t e;
        #5;
        if (!rst && pix_valid) begin
            if (q.size() == 0) begin
                checks++; fails++;
                $display("FAIL R4 unexpected pixel at edge %0d: got valid=1 expected valid=0", cyc);
            end else begin
                e = q.pop_front();
                checks++;
                if (pix_luma !== e.y || pix_chroma !== e.c) begin
                    fails++;
                    $display("FAIL %s R7 data: got y=%h c=%h expected y=%h c=%h",
                             e.r9 ? "R9" : (e.mode == 0 ? "R1" : (e.mode == 1 ? "R5" : "R6")),
                             pix_luma, pix_chroma, e.y, e.c);
                end
                checks++;
                if (pix_is_cb !== e.cb) begin
                    fails++;
                    $display("FAIL %s cb flag: got %0b expected %0b",
                             e.first ? "R3" : "R2", pix_is_cb, e.cb);
                end
                checks++;
                if (cyc != e.edge_n) begin
                    fails++;
                    $display("FAIL R8 latency: got edge %0d expected edge %0d", cyc, e.edge_n);
                end
            end
        end
    end

    task automatic idle_2x(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); #1;
            vid_de = 1'b0; vid_data = 12'hABC;
        end
    endtask

    // mode: 0 = single-edge 2x, 1 = double-edge rise first, 2 = double-edge fall first
    task automatic run_line(input int mode, input int w, input int n, input int seed, input int r9);
        @(negedge clk); #1;
        vid_de = 1'b0;
        cfg_ddr = (mode != 0);
        cfg_rise_first = (mode != 2);
        cfg_width = 2'(w);
        idle_2x(2);
        if (mode == 0) begin
            for (int i = 0; i < n; i++) begin
                @(negedge clk); #1;
                vid_de = 1'b1; vid_data = smp(seed, i);
                if (r9 != 0 && i == 4) begin cfg_ddr = 1'b1; cfg_width = 2'b10; cfg_rise_first = 1'b0; end
                if (r9 != 0 && i == n - 1) begin cfg_ddr = 1'b0; cfg_width = 2'(w); cfg_rise_first = 1'b1; end
                if (i % 2 == 1) push(smp(seed, i - 1), smp(seed, i), i / 2, cyc + 2, mode, w, r9);
            end
            idle_2x(3);
        end else begin
            for (int p = 0; p < (n + 1) / 2 + 3; p++) begin
                logic fde, sde;
                int e1;
                fde = (2 * p < n);
                sde = (2 * p + 1 < n);
                if (mode == 1) begin
                    @(negedge clk); #1;
                    vid_de = fde; vid_data = smp(seed, 2 * p);
                    e1 = cyc + 1;
                    @(posedge clk); #1;
                    vid_de = sde; vid_data = smp(seed, 2 * p + 1);
                    if (sde) push(smp(seed, 2 * p), smp(seed, 2 * p + 1), p, e1 + 1, mode, w, 0);
                end else begin
                    @(posedge clk); #1;
                    vid_de = fde; vid_data = smp(seed, 2 * p);
                    @(negedge clk); #1;
                    vid_de = sde; vid_data = smp(seed, 2 * p + 1);
                    if (sde) push(smp(seed, 2 * p), smp(seed, 2 * p + 1), p, cyc + 2, mode, w, 0);
                end
            end
            @(negedge clk); #1;
            vid_de = 1'b0;
        end
        idle_2x(1);
        // R4 R8: every expected pixel appeared, none left pending
        checks++;
        if (q.size() != 0) begin
            fails++;
            $display("FAIL R4 pixel count mode %0d width %0d len %0d: got %0d pending expected 0",
                     mode, w, n, q.size());
            q.delete();
        end
    endtask

    initial begin
        vid_data = 12'hFFF;
        vid_de = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        // R10: reset state
        checks++;
        if (pix_valid !== 1'b0 || pix_luma !== 12'h000 || pix_chroma !== 12'h000 || pix_is_cb !== 1'b0) begin
            fails++;
            $display("FAIL R10 reset: got v=%0b y=%h c=%h cb=%0b expected all zero",
                     pix_valid, pix_luma, pix_chroma, pix_is_cb);
        end
        vid_de = 1'b0;
        rst = 1'b0;
        idle_2x(2);
        for (int m = 0; m < 3; m++)
            for (int w = 0; w < 4; w++)
                for (int n = 1; n <= 7; n++)
                    run_line(m, w, n, m * 97 + w * 31 + n, 0);
        // R9: mode and width toggled while enable is high
        run_line(0, 0, 8, 555, 1);
        run_line(0, 1, 8, 777, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #2000000;
        checks++; fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule